// File: doc/BRIEF.md
# Split-Row Threshold Check Processor

This block performs the check-node update of one parity-check row in a min-sum LDPC decoder. The row's variable-to-check messages are divided evenly among `N_PART` partitions. Each partition searches only its own slice for the smallest and second-smallest magnitude, and for the position of the smallest. No minimum value crosses a partition boundary. Partitions exchange only two bits each: a flag that is raised when the local minimum is strictly below a fixed threshold, and the sign parity of the slice.

A partition that sees a raised flag from any other partition clamps its minimum and second minimum to the threshold. The threshold stands in for the remote minimum, which the partition never sees. Without a remote flag, the local values are used unchanged. Each edge gets the minimum, except the edge that holds the minimum, which gets the second minimum. The sign of each edge is the parity of every other sign in the whole row.

A `start_i` strobe captures one row per decoding iteration into output registers, and `valid_o` pulses to mark the new result.

Top module: `srt_check_row`

## Requirements
- R1: After reset `valid_o`, `flag_o` and `c2v_o` are zero. `valid_o` is high for exactly the one cycle after each cycle in which `start_i` is high.
- R2: `flag_o[p]` is 1 exactly when the smallest input magnitude of partition p is strictly less than `THRESH`. A minimum equal to `THRESH` does not raise the flag. Partition p holds edges p*PW to p*PW+PW-1, with PW = ROW_W/N_PART.
- R3: When no partition other than p raises its flag, partition p outputs its local minimum on every edge except the minimum's own edge, which gets the local second minimum.
- R4: When any other partition raises its flag, partition p applies the R3 rule to min(local minimum, THRESH) and min(local second minimum, THRESH).
- R5: On equal magnitudes, the lowest-numbered edge of the partition counts as the minimum's position. The second minimum is the smallest magnitude among the partition's other edges, so a tie makes it equal to the minimum.
- R6: The output sign of edge e is the XOR of the input signs of all ROW_W edges except e.
- R7: While `start_i` is low, `c2v_o` and `flag_o` hold their values whatever `v2c_i` does.
- R8: Every message is 5-bit sign-magnitude at bits e*5+4..e*5 of the bus. Bit 4 is the sign (1 = negative) and bits 3..0 are the magnitude. Output magnitudes never exceed the largest input magnitude (15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the current row result |
| v2c_i | input | ROW_W*(MAG_W+1) | Variable-to-check messages, sign-magnitude |
| valid_o | output | 1 | One-cycle strobe for a new result |
| flag_o | output | N_PART | Registered per-partition below-threshold flags |
| c2v_o | output | ROW_W*(MAG_W+1) | Registered check-to-variable messages |

## Verification
The datapath is combinational up to one register stage. `c2v_o`, `flag_o` and `valid_o` therefore all change on the first rising edge after `start_i` is seen high. One edge later, `valid_o` drops. The bench drives inputs on falling edges and samples results on the next falling edge, one rising edge after the strobe. It checks the strobe's fall one edge after that, and the hold behaviour after a further edge with changed inputs and no strobe. The expected messages come from a min-sum computation in the bench, applied to directed threshold, tie and sign cases and to random rows.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int SRT_ROW_W  = 32;
  localparam int SRT_N_PART = 4;
  localparam int SRT_MAG_W  = 4;
  // threshold 0.2 with magnitude LSB = 1/8 rounds to 2
  localparam int SRT_THRESH = 2;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/srt_min_tracker.sv
module srt_min_tracker #(
  parameter int PW    = 8,
  parameter int MAG_W = 4,
  localparam int IDX_W = srt_pkg::idx_width(PW)
) (
  input  logic [PW-1:0][MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0]         min1_o,
  output logic [MAG_W-1:0]         min2_o,
  output logic [IDX_W-1:0]         idx_o
);
  always_comb begin
    min1_o = '1;
    min2_o = '1;
    idx_o  = '0;
    for (int i = 0; i < PW; i++) begin
      if (mag_i[i] < min1_o) begin
        min2_o = min1_o;
        min1_o = mag_i[i];
        idx_o  = IDX_W'(i);
      end else if (mag_i[i] < min2_o) begin
        min2_o = mag_i[i];
      end
    end
  end

  always_comb begin
    AST_MIN_ORDER: assert (min1_o <= min2_o) else $error("min order"); // R5
    AST_IDX_HOLDS_MIN: assert (mag_i[idx_o] == min1_o) else $error("idx"); // R5
  end
endmodule

// File: rtl/srt_flag_chain.sv
module srt_flag_chain #(
  parameter int N_PART = 4
) (
  input  logic [N_PART-1:0] flag_i,
  input  logic [N_PART-1:0] par_i,
  output logic [N_PART-1:0] rflag_o,
  output logic [N_PART-1:0] rpar_o
);
  // left and right ripple chains; each partition sees all others
  logic [N_PART:0] pre_f, pre_p, suf_f, suf_p;

  assign pre_f[0]      = 1'b0;
  assign pre_p[0]      = 1'b0;
  assign suf_f[N_PART] = 1'b0;
  assign suf_p[N_PART] = 1'b0;

  for (genvar p = 0; p < N_PART; p++) begin : g_chain
    assign pre_f[p+1] = pre_f[p] | flag_i[p];
    assign pre_p[p+1] = pre_p[p] ^ par_i[p];
    assign suf_f[p]   = suf_f[p+1] | flag_i[p];
    assign suf_p[p]   = suf_p[p+1] ^ par_i[p];
    assign rflag_o[p] = pre_f[p] | suf_f[p+1];
    assign rpar_o[p]  = pre_p[p] ^ suf_p[p+1];
  end

  always_comb begin
    if (flag_i == '0)
      AST_NO_REMOTE: assert (rflag_o == '0) else $error("spurious remote flag"); // R3
    if ($countones(flag_i) > 1)
      AST_ALL_REMOTE: assert (&rflag_o) else $error("lost remote flag"); // R4
  end
endmodule

// File: rtl/srt_partition.sv
module srt_partition #(
  parameter int PW     = 8,
  parameter int MAG_W  = 4,
  parameter int THRESH = 2,
  localparam int EW    = MAG_W + 1,
  localparam int IDX_W = srt_pkg::idx_width(PW)
) (
  input  logic [PW*EW-1:0] v2c_i,
  input  logic             rflag_i,
  input  logic             rpar_i,
  output logic             flag_o,
  output logic             par_o,
  output logic [PW*EW-1:0] c2v_o
);
  localparam logic [MAG_W-1:0] TH = MAG_W'(THRESH);

  logic [PW-1:0][MAG_W-1:0] mag;
  logic [PW-1:0]            sgn;
  logic [MAG_W-1:0]         min1, min2, sel1, sel2;
  logic [IDX_W-1:0]         idx;

  for (genvar i = 0; i < PW; i++) begin : g_unpack
    assign mag[i] = v2c_i[i*EW +: MAG_W];
    assign sgn[i] = v2c_i[i*EW + MAG_W];
  end

  srt_min_tracker #(.PW(PW), .MAG_W(MAG_W)) u_min (
    .mag_i (mag),
    .min1_o(min1),
    .min2_o(min2),
    .idx_o (idx)
  );

  assign flag_o = (min1 < TH);
  assign par_o  = ^sgn;

  // remote minimum unknown: threshold stands in when a neighbour flags
  assign sel1 = (rflag_i && (TH < min1)) ? TH : min1;
  assign sel2 = (rflag_i && (TH < min2)) ? TH : min2;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      c2v_o[i*EW +: EW] = {rpar_i ^ par_o ^ sgn[i],
                           (IDX_W'(i) == idx) ? sel2 : sel1};
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      if (rflag_i)
        AST_CLAMP_TH: assert (c2v_o[i*EW +: MAG_W] <= TH) else $error("clamp"); // R4
    end
  end
endmodule

// File: rtl/srt_check_row.sv
module srt_check_row #(
  parameter int ROW_W  = srt_pkg::SRT_ROW_W,
  parameter int N_PART = srt_pkg::SRT_N_PART,
  parameter int MAG_W  = srt_pkg::SRT_MAG_W,
  parameter int THRESH = srt_pkg::SRT_THRESH,
  localparam int EW    = MAG_W + 1,
  localparam int VW    = ROW_W * EW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VW-1:0]     v2c_i,
  output logic              valid_o,
  output logic [N_PART-1:0] flag_o,
  output logic [VW-1:0]     c2v_o
);
  localparam int PW = ROW_W / N_PART;
  localparam int SW = PW * EW;

  logic [N_PART-1:0] flag, par, rflag, rpar;
  logic [VW-1:0]     c2v_d;

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    srt_partition #(.PW(PW), .MAG_W(MAG_W), .THRESH(THRESH)) u_part (
      .v2c_i  (v2c_i[p*SW +: SW]),
      .rflag_i(rflag[p]),
      .rpar_i (rpar[p]),
      .flag_o (flag[p]),
      .par_o  (par[p]),
      .c2v_o  (c2v_d[p*SW +: SW])
    );
  end

  srt_flag_chain #(.N_PART(N_PART)) u_chain (
    .flag_i (flag),
    .par_i  (par),
    .rflag_o(rflag),
    .rpar_o (rpar)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flag_o  <= '0;
      c2v_o   <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        flag_o <= flag;
        c2v_o  <= c2v_d;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i)) else $error("valid without start"); // R1
  AST_VALID_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o) else $error("missing valid"); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(c2v_o) && $stable(flag_o))) else $error("output moved"); // R7
endmodule

// File: tb/sim_srt_check_row.sv
module sim_srt_check_row;
  localparam int ROW_W = 32;
  localparam int NP    = 4;
  localparam int MW    = 4;
  localparam int TH    = 2;
  localparam int EW    = MW + 1;
  localparam int PW    = ROW_W / NP;
  localparam int VW    = ROW_W * EW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [VW-1:0] v2c_i = '0;
  logic          valid_o;
  logic [NP-1:0] flag_o;
  logic [VW-1:0] c2v_o;

  int n_chk = 0;
  int n_err = 0;
  logic [VW-1:0] smask, mmask;

  always #2 clk = ~clk;

  srt_check_row #(.ROW_W(ROW_W), .N_PART(NP), .MAG_W(MW), .THRESH(TH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .v2c_i(v2c_i),
    .valid_o(valid_o), .flag_o(flag_o), .c2v_o(c2v_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench-side min-sum with threshold substitution
  function automatic void ref_row(input logic [VW-1:0] v, output logic [VW-1:0] c,
                                  output logic [NP-1:0] f, output bit any_rem);
    int m1[NP]; int m2[NP]; int ix[NP];
    bit tot;
    tot = 0;
    for (int e = 0; e < ROW_W; e++) tot ^= v[e*EW + MW];
    for (int p = 0; p < NP; p++) begin
      m1[p] = 99; ix[p] = 0; m2[p] = 15;
      for (int i = 0; i < PW; i++)
        if (int'(v[(p*PW+i)*EW +: MW]) < m1[p]) begin
          m1[p] = int'(v[(p*PW+i)*EW +: MW]); ix[p] = i;
        end
      for (int i = 0; i < PW; i++)
        if (i != ix[p] && int'(v[(p*PW+i)*EW +: MW]) < m2[p])
          m2[p] = int'(v[(p*PW+i)*EW +: MW]);
      f[p] = (m1[p] < TH);
    end
    any_rem = 0;
    for (int p = 0; p < NP; p++) begin
      bit rem;
      int a, b;
      rem = 0;
      for (int q = 0; q < NP; q++) if (q != p && f[q]) rem = 1;
      a = m1[p]; b = m2[p];
      if (rem) begin
        any_rem = 1;
        if (a > TH) a = TH;
        if (b > TH) b = TH;
      end
      for (int i = 0; i < PW; i++) begin
        int e;
        e = p*PW + i;
        c[e*EW + MW] = tot ^ v[e*EW + MW];
        c[e*EW +: MW] = MW'((i == ix[p]) ? b : a);
      end
    end
  endfunction

  task automatic apply(input logic [VW-1:0] v, input string tag);
    logic [VW-1:0] ec;
    logic [NP-1:0] ef;
    bit anyr;
    string mt;
    ref_row(v, ec, ef, anyr);
    mt = (tag != "") ? tag : (anyr ? "R4 clamp" : "R3 local");
    @(negedge clk);
    v2c_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1, "R1 valid due", VW'(valid_o), VW'(1));
    chk(flag_o === ef, "R2 flags", VW'(flag_o), VW'(ef));
    chk((c2v_o & smask) === (ec & smask), "R6 signs", c2v_o & smask, ec & smask);
    chk((c2v_o & mmask) === (ec & mmask), mt, c2v_o & mmask, ec & mmask);
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 single pulse", VW'(valid_o), VW'(0));
    v2c_i = ~v;
    @(negedge clk);
    chk(c2v_o === ec && flag_o === ef, "R7 hold", c2v_o, ec);
  endtask

  function automatic logic [VW-1:0] put(input logic [VW-1:0] v, input int e,
                                        input bit s, input int m);
    v[e*EW +: EW] = {s, MW'(m)};
    return v;
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    for (int e = 0; e < ROW_W; e++) begin
      smask[e*EW +: EW] = {1'b1, {MW{1'b0}}};
      mmask[e*EW +: EW] = {1'b0, {MW{1'b1}}};
    end
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && flag_o === '0 && c2v_o === '0, "R1 reset state", c2v_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 idle after reset", VW'(valid_o), VW'(0));

    // R3 none below T; magnitude exactly T leaves flag low (R2)
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, (e % 3) == 0, TH + (e % 14));
    apply(v, "R3 none below T");

    // R4 all partitions below T
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, (e % 5) == 1, e % 2);
    apply(v, "R4 all below T");

    // R4 one partition flags, others clamp
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, e[0], 3 + (e % 13));
    v = put(v, 2*PW + 5, 1'b0, 1);
    apply(v, "R4 one flag");

    // R5 tie without flags
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, 1'b0, 9);
    v = put(v, 2, 1'b1, 4);
    v = put(v, 6, 1'b0, 4);
    v = put(v, PW + 1, 1'b0, 7);
    apply(v, "R5 tie");

    // R5 tie below T in one partition
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, 1'b1, 5 + (e % 11));
    v = put(v, PW, 1'b0, 0);
    v = put(v, PW + 3, 1'b0, 0);
    apply(v, "R5 tie below T");

    // R8 encoding: one negative edge, full-scale magnitudes
    v = '0;
    for (int e = 0; e < ROW_W; e++) v = put(v, e, 1'b0, 15);
    v = put(v, 0, 1'b1, 15);
    apply(v, "R8 sign-magnitude full scale");

    for (int n = 0; n < 800; n++) begin
      v = '0;
      for (int e = 0; e < ROW_W; e++)
        v = put(v, e, 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
      apply(v, "");
    end
    for (int n = 0; n < 800; n++) begin
      v = '0;
      for (int e = 0; e < ROW_W; e++)
        v = put(v, e, 1'($urandom_range(0, 1)), int'($urandom_range(1, 5)));
      apply(v, "");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule